// File: doc/BRIEF.md
# Interface Command Sequencer

The sequencer sits between a processor's start-I/O command decode and a microcode task scheduler for a serial interface. It watches an active-low command strobe and an active-low 2-bit command code. From the command it picks a wakeup request for the scheduler and keeps that request asserted while the strobe is held. For the commands that need a task to run, it also keeps the request asserted after the strobe is released, until the scheduler acknowledges it. While no command is in progress, it forwards the interface's input-data and output-data requests as wakeups, and input takes priority over output.

Four states are held in a 2-bit register: idle, start-output, set-control and start-input. The next-state and wakeup logic is combinational and feeds that register. The wakeup code is registered alongside the state, so every output follows its inputs by one clock. A valid flag tells wakeup code 0 apart from no request. A scheduler-facing copy of the code is also provided. It is stored active-low, and its low bit is inverted once more.

Top module: `ics_cmd_seq`

## Requirements
- R1: While rst_ni is low, and after it rises until the first input takes effect, state_o is 0, wake_valid_o is 0, wake_code_o is 0 and wake_sched_o is 2'b10.
- R2: state_o encodes idle as 0, start-output as 1, set-control as 2 and start-input as 3.
- R3: In idle with strobe_ni low, the true command code is ~cmd_ni. Code 3 moves to set-control with wakeup 0. Code 2 moves to start-input with wakeup 1. Code 1 moves to start-output with no wakeup.
- R4: In idle with strobe_ni low and code 0 (cmd_ni=2'b11), the state stays idle and no wakeup is raised.
- R5: In idle with strobe_ni high, in_req_ni low gives wakeup 2. Otherwise, out_req_ni low gives wakeup 3. Otherwise, no wakeup is raised. The state stays idle in all three cases.
- R6: Start-output holds while strobe_ni is low and returns to idle one clock after strobe_ni is high. It never raises a wakeup.
- R7: Start-input raises wakeup 1 on every clock while strobe_ni is low, whatever ack_ni is. Once strobe_ni is high, it keeps wakeup 1 until ack_ni is low, and then returns to idle with no wakeup.
- R8: Set-control behaves like start-input but raises wakeup 0.
- R9: in_req_ni and out_req_ni have no effect outside idle.
- R10: wake_sched_o equals {~c[1], c[0]}, where c is wake_code_o when wake_valid_o is 1 and 0 otherwise.
- R11: state_o and all wakeup outputs change only on a rising clock edge, one clock after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_ni | input | 1 | Start-I/O command strobe, active low |
| cmd_ni | input | 2 | Command code, active low |
| ack_ni | input | 1 | Wakeup acknowledge from scheduler, active low |
| in_req_ni | input | 1 | Input-data wakeup request, active low |
| out_req_ni | input | 1 | Output-data wakeup request, active low |
| state_o | output | 2 | Current state |
| wake_valid_o | output | 1 | A wakeup request is present |
| wake_code_o | output | 2 | Wakeup code, true polarity |
| wake_sched_o | output | 2 | Scheduler-facing code: high bit active low, low bit true |

## Verification
The assertions check on every clock the hold-and-release rules of the three busy states, the silence of start-output, the input-over-output priority in idle, and the idle code-0 case. The bench's scenarios are needed to show the reset values, the exact decode of each command, that data requests are ignored while a command is in progress, and the scheduler encoding. A long pseudo-random run against the behavioural model covers the one-clock latency under mixed inputs.

// File: rtl/ics_pkg.sv
package ics_pkg;
  localparam int unsigned ST_W   = 2;
  localparam int unsigned WAKE_W = 2;
  localparam int unsigned CMD_W  = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 2'd0,
    ST_OUT    = 2'd1,
    ST_CTL    = 2'd2,
    ST_IN     = 2'd3
  } state_e;

  localparam logic [WAKE_W-1:0] WK_CTL  = 2'd0;
  localparam logic [WAKE_W-1:0] WK_INS  = 2'd1;
  localparam logic [WAKE_W-1:0] WK_IDAT = 2'd2;
  localparam logic [WAKE_W-1:0] WK_ODAT = 2'd3;

  localparam logic [CMD_W-1:0] CMD_NONE = 2'd0;
  localparam logic [CMD_W-1:0] CMD_OUT  = 2'd1;
  localparam logic [CMD_W-1:0] CMD_IN   = 2'd2;
  localparam logic [CMD_W-1:0] CMD_CTL  = 2'd3;

  typedef struct packed {
    logic              strobe;
    logic [CMD_W-1:0]  cmd;
    logic              ack;
    logic              in_req;
    logic              out_req;
  } req_t;

  typedef struct packed {
    logic              valid;
    logic [WAKE_W-1:0] code;
  } wake_t;
endpackage

// File: rtl/ics_in_cond.sv
module ics_in_cond
  import ics_pkg::*;
(
  input  logic             strobe_ni,
  input  logic [CMD_W-1:0] cmd_ni,
  input  logic             ack_ni,
  input  logic             in_req_ni,
  input  logic             out_req_ni,
  output req_t             req_o
);
  always_comb begin
    req_o.strobe  = ~strobe_ni;
    req_o.cmd     = ~cmd_ni;
    req_o.ack     = ~ack_ni;
    req_o.in_req  = ~in_req_ni;
    req_o.out_req = ~out_req_ni;
  end
endmodule

// File: rtl/ics_next.sv
module ics_next
  import ics_pkg::*;
(
  input  state_e cur_i,
  input  req_t   req_i,
  output state_e nxt_o,
  output wake_t  wake_o
);
  always_comb begin
    nxt_o  = cur_i;
    wake_o = '0;
    unique case (cur_i)
      ST_IDLE: begin
        if (req_i.strobe) begin
          unique case (req_i.cmd)
            CMD_CTL: begin nxt_o = ST_CTL; wake_o = '{valid: 1'b1, code: WK_CTL}; end
            CMD_IN:  begin nxt_o = ST_IN;  wake_o = '{valid: 1'b1, code: WK_INS}; end
            CMD_OUT: nxt_o = ST_OUT;
            default: nxt_o = ST_IDLE;
          endcase
        end else if (req_i.in_req) begin
          wake_o = '{valid: 1'b1, code: WK_IDAT};
        end else if (req_i.out_req) begin
          wake_o = '{valid: 1'b1, code: WK_ODAT};
        end
      end
      ST_OUT: if (!req_i.strobe) nxt_o = ST_IDLE;
      ST_IN, ST_CTL: begin
        // request persists until acknowledged after strobe release
        if (!req_i.strobe && req_i.ack) begin
          nxt_o = ST_IDLE;
        end else begin
          wake_o.valid = 1'b1;
          wake_o.code  = (cur_i == ST_IN) ? WK_INS : WK_CTL;
        end
      end
      default: nxt_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/ics_out_reg.sv
module ics_out_reg
  import ics_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            nxt_i,
  input  wake_t             wake_i,
  output state_e            cur_o,
  output logic              valid_o,
  output logic [WAKE_W-1:0] code_o,
  output logic [WAKE_W-1:0] sched_o
);
  logic [WAKE_W-1:0] stored_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o      <= ST_IDLE;
      valid_o    <= 1'b0;
      code_o     <= '0;
      stored_n_q <= '1;
    end else begin
      cur_o      <= nxt_i;
      valid_o    <= wake_i.valid;
      code_o     <= wake_i.code;
      stored_n_q <= wake_i.valid ? ~wake_i.code : '1;
    end
  end

  // low bit flipped back to true polarity on the way out
  always_comb begin
    sched_o    = stored_n_q;
    sched_o[0] = ~stored_n_q[0];
  end
endmodule

// File: rtl/ics_cmd_seq.sv
module ics_cmd_seq
  import ics_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_ni,
  input  logic [1:0] cmd_ni,
  input  logic       ack_ni,
  input  logic       in_req_ni,
  input  logic       out_req_ni,
  output logic [1:0] state_o,
  output logic       wake_valid_o,
  output logic [1:0] wake_code_o,
  output logic [1:0] wake_sched_o
);
  req_t   req;
  state_e cur, nxt;
  wake_t  wake;

  ics_in_cond u_in (
    .strobe_ni (strobe_ni),
    .cmd_ni    (cmd_ni),
    .ack_ni    (ack_ni),
    .in_req_ni (in_req_ni),
    .out_req_ni(out_req_ni),
    .req_o     (req)
  );

  ics_next u_next (
    .cur_i (cur),
    .req_i (req),
    .nxt_o (nxt),
    .wake_o(wake)
  );

  ics_out_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt),
    .wake_i (wake),
    .cur_o  (cur),
    .valid_o(wake_valid_o),
    .code_o (wake_code_o),
    .sched_o(wake_sched_o)
  );

  assign state_o = cur;
endmodule

// File: rtl/ics_cmd_seq_chk.sv
module ics_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       strobe_ni,
  input logic [1:0] cmd_ni,
  input logic       ack_ni,
  input logic       in_req_ni,
  input logic       out_req_ni,
  input logic [1:0] state_o,
  input logic       wake_valid_o,
  input logic [1:0] wake_code_o,
  input logic [1:0] wake_sched_o
);
  a_r6_out_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && strobe_ni) |=> (state_o == 2'd0 && !wake_valid_o));

  a_r6_out_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |-> !wake_valid_o);

  a_r7_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && (!strobe_ni || ack_ni))
      |=> (state_o == 2'd3 && wake_valid_o && wake_code_o == 2'd1));

  a_r8_ctl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && (!strobe_ni || ack_ni))
      |=> (state_o == 2'd2 && wake_valid_o && wake_code_o == 2'd0));

  a_r7_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[1] && strobe_ni && !ack_ni) |=> (state_o == 2'd0 && !wake_valid_o));

  a_r5_in_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && strobe_ni && !in_req_ni)
      |=> (state_o == 2'd0 && wake_valid_o && wake_code_o == 2'd2));

  a_r4_code_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && !strobe_ni && cmd_ni == 2'b11)
      |=> (state_o == 2'd0 && !wake_valid_o));
endmodule

bind ics_cmd_seq ics_cmd_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .strobe_ni   (strobe_ni),
  .cmd_ni      (cmd_ni),
  .ack_ni      (ack_ni),
  .in_req_ni   (in_req_ni),
  .out_req_ni  (out_req_ni),
  .state_o     (state_o),
  .wake_valid_o(wake_valid_o),
  .wake_code_o (wake_code_o),
  .wake_sched_o(wake_sched_o)
);

// File: tb/ics_cmd_seq_tb.sv
module ics_cmd_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strobe_ni = 1'b1;
  logic [1:0] cmd_ni = 2'b11;
  logic       ack_ni = 1'b1;
  logic       in_req_ni = 1'b1;
  logic       out_req_ni = 1'b1;
  logic [1:0] state_o;
  logic       wake_valid_o;
  logic [1:0] wake_code_o;
  logic [1:0] wake_sched_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model: state number, pending wakeup (-1 = none)
  int m_state = 0;
  int m_wake  = -1;

  always #10 clk_i = ~clk_i;

  ics_cmd_seq u_dut (.*);

  task automatic check(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic compare(string tag);
    int c;
    c = (m_wake < 0) ? 0 : m_wake;
    check(tag, state_o, m_state, "state");
    check(tag, wake_valid_o, (m_wake >= 0) ? 1 : 0, "valid");
    if (m_wake >= 0) check(tag, wake_code_o, m_wake, "code");
    check(tag, wake_sched_o, ((1 - c / 2) * 2) + (c % 2), "sched");
  endtask

  // drive one clock of inputs (true polarity), advance the model, compare
  task automatic step(string tag, bit s, int cmd, bit a, bit ir, bit orq);
    int ns, nw;
    strobe_ni = ~s; cmd_ni = ~2'(cmd); ack_ni = ~a; in_req_ni = ~ir; out_req_ni = ~orq;
    ns = m_state; nw = -1;
    if (m_state == 0) begin
      if (s) begin
        if (cmd == 3) begin ns = 2; nw = 0; end
        else if (cmd == 2) begin ns = 3; nw = 1; end
        else if (cmd == 1) ns = 1;
      end else if (ir) nw = 2;
      else if (orq) nw = 3;
    end else if (m_state == 1) begin
      if (!s) ns = 0;
    end else begin
      if (!s && a) ns = 0;
      else nw = (m_state == 3) ? 1 : 0;
    end
    @(posedge clk_i);
    m_state = ns; m_wake = nw;
    @(negedge clk_i);
    compare(tag);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after reset");

    // R3 R8: set-control with ack during strobe and data requests
    step("R3 ctl", 1, 3, 0, 0, 0);
    step("R8 ack while strobe", 1, 3, 1, 0, 0);
    step("R9 data in ctl", 1, 3, 0, 1, 1);
    step("R8 released no ack", 0, 0, 0, 1, 0);
    step("R8 ack", 0, 0, 1, 0, 0);
    step("R2 idle", 0, 0, 0, 0, 0);
    // R3 R7: start-input
    step("R3 in", 1, 2, 0, 0, 0);
    step("R7 ack while strobe", 1, 2, 1, 0, 0);
    step("R7 released", 0, 0, 0, 0, 1);
    step("R9 data in start-input", 0, 0, 0, 1, 1);
    step("R7 ack", 0, 0, 1, 1, 0);
    // R3 R6: start-output
    step("R3 out", 1, 1, 0, 0, 0);
    step("R6 hold", 1, 1, 1, 1, 1);
    step("R6 release", 0, 0, 0, 1, 1);
    // R4
    step("R4 code0", 1, 0, 0, 1, 1);
    // R5 priority
    step("R5 both", 0, 0, 0, 1, 1);
    step("R5 output only", 0, 0, 0, 0, 1);
    step("R5 none", 0, 0, 1, 0, 0);
    step("R10 input sched", 0, 0, 0, 1, 0);

    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R11 random", lfsr[0] & lfsr[5], int'(lfsr[2:1]), lfsr[3] & lfsr[7],
           lfsr[4] & lfsr[9], lfsr[6]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule